// File: doc/BRIEF.md
# Host Register Slave with Strobe/Acknowledge Handshake

This block is the register front end of a two-wire serial controller. A host on a simple synchronous bus selects it with a chip select and a strobe. A read/write level gives the direction, and a 4-bit address picks one of fifteen registers. Every bus cycle moves one 10-bit value. The slave raises an acknowledge after a configurable number of wait states and keeps it up until the host removes the strobe. Read data is captured when the acknowledge rises and does not change while the acknowledge stays high.

The serial protocol engine is not part of this block. It appears only as status inputs (received data, general-call data, status words, byte counts, interrupt-flag set pulses) and as configuration and pulse outputs. Some addresses have side effects when accessed:
- a write to the control register or to either prescale byte resets the core;
- in FIFO mode, a read of the transmit address or a write of the receive address resets that FIFO's pointers;
- a write to a byte-count address clears that counter;
- the interrupt-flag register clears by write-one or, optionally, on read.

The interrupt request combines the flags, their enables and a force bit.

Top module: `hbus_regslave`

## Requirements
- R1: A request is `bus_stb` and `bus_cs` both high. `bus_ack` rises exactly `WAIT_STATES`+1 clock edges after the first edge that sees the request. It stays high while the request is held, and it falls on the first edge that sees the request removed. Without `bus_cs`, `bus_ack` stays low and no register changes.
- R2: Each bus cycle performs its access once. Every side-effect pulse (`core_rst`, `tx_wr`, `txfifo_rst`, `rxfifo_rst`, `txcnt_clr`, `rxcnt_clr`) is high for exactly the first cycle in which `bus_ack` is high, and low again in the next cycle.
- R3: `bus_rdata` is captured on the edge that raises `bus_ack`. It stays stable while `bus_ack` stays high, even if the status inputs change.
- R4: The following addresses read back the last written value:
  - 0x1 control, 0x2 prescale low, 0x3 prescale high and 0x7 command keep 8 bits (upper two read 0);
  - 0x4 slave address, 0x5 interrupt control and 0x6 threshold keep all 10 bits;
  - all of them reset to 0.
- R5: Address 0x0 reads 0 and ignores writes. Address 0x8 reads 0. A write to 0x8 pulses `tx_wr` with the written value on `tx_data`.
- R6: A write to 0x1, 0x2 or 0x3 pulses `core_rst`. Reads of those addresses, and writes to any other address, do not.
- R7: When control bit 4 (FIFO mode) is 1, a read of 0x8 pulses `txfifo_rst` and a write of 0x9 pulses `rxfifo_rst`. When the bit is 0, neither pulse occurs. A write to 0x8 never pulses `txfifo_rst`.
- R8: A write to 0xE pulses `txcnt_clr` only, and a write to 0xF pulses `rxcnt_clr` only.
- R9: The status inputs read back unchanged at these addresses: 0x9 receive data, 0xA general-call data, 0xB status, 0xD state-machine status, 0xE transmit count, 0xF receive count.
- R10: Interrupt flags are set by `core_flag_set` and read at 0xC. Writing 1 to a bit of 0xC clears that flag, and writing 0 leaves it.
- R11: When interrupt-control bit 8 (auto-clear) is 1, a read of 0xC returns the flags and then clears all of them. When it is 0, a read leaves them.
- R12: A flag set by `core_flag_set` in the same cycle as a write-clear or read-clear of that flag stays set. A read in that cycle returns the value before the set.
- R13: `irq` is high when interrupt-control bit 9 (force) is 1, or when any flag is set whose enable bit (interrupt-control bits 7:0) is 1. Otherwise `irq` is low.
- R14: After reset, `bus_ack`, `irq` and every pulse output are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_cs | input | 1 | Chip select |
| bus_stb | input | 1 | Transfer strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 10 | Write data |
| bus_rdata | output | 10 | Read data, valid while `bus_ack` is high |
| bus_ack | output | 1 | Transfer acknowledge |
| core_rx_data | input | 10 | Received data from core |
| core_gc_data | input | 10 | General-call data from core |
| core_status | input | 10 | Core status word |
| core_sm_status | input | 10 | Core FIFO state-machine status |
| core_tx_count | input | 10 | Transmit byte count |
| core_rx_count | input | 10 | Receive byte count |
| core_flag_set | input | 8 | Interrupt-flag set pulses from core |
| cfg_ctrl | output | 8 | Control register |
| cfg_prescale | output | 16 | Prescale, high byte over low byte |
| cfg_saddr | output | 10 | Own slave address |
| cfg_thresh | output | 10 | FIFO threshold |
| cfg_cmd | output | 8 | Command register |
| tx_data | output | 10 | Last value written to 0x8 |
| tx_wr | output | 1 | Pulse on write to 0x8 |
| core_rst | output | 1 | Core reset pulse |
| txfifo_rst | output | 1 | Transmit FIFO pointer reset pulse |
| rxfifo_rst | output | 1 | Receive FIFO pointer reset pulse |
| txcnt_clr | output | 1 | Transmit count clear pulse |
| rxcnt_clr | output | 1 | Receive count clear pulse |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can land on the same edge: the core setting an interrupt flag, and a host access that clears flags, either by a write-one or by an auto-clear read. The bench raises `core_flag_set` in exactly the cycle before the edge that raises the acknowledge, so the set and the clear act on the same edge. It then reads the flag register back and expects the new flag to survive while the old ones are gone. In the read case, it also expects the data returned by that read to hold the pre-set value.

// File: rtl/hbus_pkg.sv
// Package: shared widths, register addresses and handshake states for the
// host register slave. Assumes a 4-bit address and 10-bit data path.
package hbus_pkg;
    localparam int DW = 10;
    localparam int AW = 4;
    localparam int CTRL_FIFO_BIT = 4;

    typedef enum logic [AW-1:0] {
        RA_NONE    = 4'h0,
        RA_CTRL    = 4'h1,
        RA_PRE_LO  = 4'h2,
        RA_PRE_HI  = 4'h3,
        RA_SADDR   = 4'h4,
        RA_IRQ_CTL = 4'h5,
        RA_THRESH  = 4'h6,
        RA_CMD     = 4'h7,
        RA_TXD     = 4'h8,
        RA_RXD     = 4'h9,
        RA_GCALL   = 4'hA,
        RA_STAT    = 4'hB,
        RA_IRQ_FLG = 4'hC,
        RA_SM_STAT = 4'hD,
        RA_TX_CNT  = 4'hE,
        RA_RX_CNT  = 4'hF
    } reg_addr_e;

    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_WAIT = 2'd1,
        HS_DONE = 2'd2
    } hs_state_e;
endpackage

// File: rtl/hbus_handshake.sv
// Handshake engine: turns a held request into one access pulse after
// WAIT_STATES extra cycles, then holds the acknowledge until the request
// is removed. Assumes the host holds address and data stable while requesting.
module hbus_handshake
    import hbus_pkg::*;
#(
    parameter int WAIT_STATES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic ack_o,
    output logic acc_o
);
    localparam int CW = $clog2(WAIT_STATES + 2);

    hs_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // Next-state and access decision.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        acc_o   = 1'b0;
        case (state_q)
            HS_IDLE: if (req_i) begin
                if (WAIT_STATES == 0) begin
                    acc_o   = 1'b1;
                    state_d = HS_DONE;
                end else begin
                    state_d = HS_WAIT;
                    cnt_d   = CW'(1);
                end
            end
            HS_WAIT: begin
                if (!req_i) begin
                    state_d = HS_IDLE;
                end else if (cnt_q == CW'(WAIT_STATES)) begin
                    acc_o   = 1'b1;
                    state_d = HS_DONE;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            HS_DONE: if (!req_i) state_d = HS_IDLE;
            default: state_d = HS_IDLE;
        endcase
    end

    // State and wait counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign ack_o = (state_q == HS_DONE);

    p_ack_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && req_i) |=> ack_o);
    p_ack_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && !req_i) |=> !ack_o);
    p_single_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_o |=> (!acc_o && ack_o));
endmodule

// File: rtl/hbus_irq_flags.sv
// Interrupt flags: sticky bits set by the core, cleared by host write-one or
// read-clear; a set on the same edge as a clear wins. Drives the request line.
module hbus_irq_flags #(
    parameter int NFLAG = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] set_i,
    input  logic [NFLAG-1:0] wclr_i,
    input  logic             rclr_i,
    input  logic [NFLAG-1:0] en_i,
    input  logic             force_i,
    output logic [NFLAG-1:0] flags_o,
    output logic             irq_o
);
    logic [NFLAG-1:0] clr_mask;

    // Combined clear mask from both clear sources.
    always_comb clr_mask = rclr_i ? '1 : wclr_i;

    // Flag storage with set priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_o <= '0;
        else        flags_o <= (flags_o & ~clr_mask) | set_i;
    end

    // Request line from force bit and enabled flags.
    always_comb irq_o = force_i | (|(flags_o & en_i));

    p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((flags_o & $past(set_i)) == $past(set_i)));
    p_clear_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((|wclr_i) && !(|set_i) && !rclr_i) |=> ((flags_o & $past(wclr_i)) == '0));
endmodule

// File: rtl/hbus_regfile.sv
// Register file: configuration storage, read multiplexer with a capture
// register, and one-cycle side-effect pulses. Acts only on acc_i, which the
// handshake raises once per bus cycle.
module hbus_regfile
    import hbus_pkg::*;
#(
    parameter int NFLAG = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_i,
    input  logic             we_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [DW-1:0]    wdata_i,
    input  logic [DW-1:0]    rx_data_i,
    input  logic [DW-1:0]    gc_data_i,
    input  logic [DW-1:0]    status_i,
    input  logic [DW-1:0]    sm_status_i,
    input  logic [DW-1:0]    tx_count_i,
    input  logic [DW-1:0]    rx_count_i,
    input  logic [NFLAG-1:0] flags_i,
    output logic [DW-1:0]    rdata_o,
    output logic [7:0]       ctrl_o,
    output logic [15:0]      prescale_o,
    output logic [DW-1:0]    saddr_o,
    output logic [DW-1:0]    thresh_o,
    output logic [7:0]       cmd_o,
    output logic [DW-1:0]    irq_ctl_o,
    output logic [DW-1:0]    tx_data_o,
    output logic             tx_wr_o,
    output logic             core_rst_o,
    output logic             txfifo_rst_o,
    output logic             rxfifo_rst_o,
    output logic             txcnt_clr_o,
    output logic             rxcnt_clr_o,
    output logic [NFLAG-1:0] flag_wclr_o,
    output logic             flag_rclr_o
);
    reg_addr_e     ra;
    logic          wr, rd, fifo_mode;
    logic [DW-1:0] rmux;

    assign ra        = reg_addr_e'(addr_i);
    assign wr        = acc_i &  we_i;
    assign rd        = acc_i & ~we_i;
    assign fifo_mode = ctrl_o[CTRL_FIFO_BIT];

    // Read value selection for the addressed register.
    always_comb begin
        case (ra)
            RA_CTRL:    rmux = DW'(ctrl_o);
            RA_PRE_LO:  rmux = DW'(prescale_o[7:0]);
            RA_PRE_HI:  rmux = DW'(prescale_o[15:8]);
            RA_SADDR:   rmux = saddr_o;
            RA_IRQ_CTL: rmux = irq_ctl_o;
            RA_THRESH:  rmux = thresh_o;
            RA_CMD:     rmux = DW'(cmd_o);
            RA_RXD:     rmux = rx_data_i;
            RA_GCALL:   rmux = gc_data_i;
            RA_STAT:    rmux = status_i;
            RA_IRQ_FLG: rmux = DW'(flags_i);
            RA_SM_STAT: rmux = sm_status_i;
            RA_TX_CNT:  rmux = tx_count_i;
            RA_RX_CNT:  rmux = rx_count_i;
            default:    rmux = '0;
        endcase
    end

    // Flag clear requests, applied on the access edge.
    always_comb begin
        flag_wclr_o = (wr && ra == RA_IRQ_FLG) ? wdata_i[NFLAG-1:0] : '0;
        flag_rclr_o = rd && ra == RA_IRQ_FLG && irq_ctl_o[DW-2];
    end

    // Configuration registers and read capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_o     <= '0;
            prescale_o <= '0;
            saddr_o    <= '0;
            thresh_o   <= '0;
            cmd_o      <= '0;
            irq_ctl_o  <= '0;
            tx_data_o  <= '0;
            rdata_o    <= '0;
        end else if (acc_i) begin
            rdata_o <= we_i ? '0 : rmux;
            if (we_i) begin
                case (ra)
                    RA_CTRL:    ctrl_o            <= wdata_i[7:0];
                    RA_PRE_LO:  prescale_o[7:0]   <= wdata_i[7:0];
                    RA_PRE_HI:  prescale_o[15:8]  <= wdata_i[7:0];
                    RA_SADDR:   saddr_o           <= wdata_i;
                    RA_IRQ_CTL: irq_ctl_o         <= wdata_i;
                    RA_THRESH:  thresh_o          <= wdata_i;
                    RA_CMD:     cmd_o             <= wdata_i[7:0];
                    RA_TXD:     tx_data_o         <= wdata_i;
                    default:    ;
                endcase
            end
        end
    end

    // One-cycle side-effect pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_rst_o   <= 1'b0;
            tx_wr_o      <= 1'b0;
            txfifo_rst_o <= 1'b0;
            rxfifo_rst_o <= 1'b0;
            txcnt_clr_o  <= 1'b0;
            rxcnt_clr_o  <= 1'b0;
        end else begin
            core_rst_o   <= wr && (ra == RA_CTRL || ra == RA_PRE_LO || ra == RA_PRE_HI);
            tx_wr_o      <= wr && ra == RA_TXD;
            txfifo_rst_o <= rd && fifo_mode && ra == RA_TXD;
            rxfifo_rst_o <= wr && fifo_mode && ra == RA_RXD;
            txcnt_clr_o  <= wr && ra == RA_TX_CNT;
            rxcnt_clr_o  <= wr && ra == RA_RX_CNT;
        end
    end

    p_core_rst_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_o |-> $past(acc_i && we_i));
    p_pulse_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr_o || core_rst_o || txcnt_clr_o || rxcnt_clr_o) |=>
        !(tx_wr_o || core_rst_o || txcnt_clr_o || rxcnt_clr_o));
    p_fifo_rst_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (txfifo_rst_o || rxfifo_rst_o) |-> $past(fifo_mode));
endmodule

// File: rtl/hbus_regslave.sv
// Top: host register slave for a two-wire serial controller. Combines the
// handshake engine, the register file and the interrupt flags. Assumes a
// single host that keeps address, direction and data stable during a request.
module hbus_regslave
    import hbus_pkg::*;
#(
    parameter int WAIT_STATES = 1,
    parameter int NFLAG       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_cs,
    input  logic             bus_stb,
    input  logic             bus_we,
    input  logic [3:0]       bus_addr,
    input  logic [9:0]       bus_wdata,
    output logic [9:0]       bus_rdata,
    output logic             bus_ack,
    input  logic [9:0]       core_rx_data,
    input  logic [9:0]       core_gc_data,
    input  logic [9:0]       core_status,
    input  logic [9:0]       core_sm_status,
    input  logic [9:0]       core_tx_count,
    input  logic [9:0]       core_rx_count,
    input  logic [NFLAG-1:0] core_flag_set,
    output logic [7:0]       cfg_ctrl,
    output logic [15:0]      cfg_prescale,
    output logic [9:0]       cfg_saddr,
    output logic [9:0]       cfg_thresh,
    output logic [7:0]       cfg_cmd,
    output logic [9:0]       tx_data,
    output logic             tx_wr,
    output logic             core_rst,
    output logic             txfifo_rst,
    output logic             rxfifo_rst,
    output logic             txcnt_clr,
    output logic             rxcnt_clr,
    output logic             irq
);
    logic             acc;
    logic [NFLAG-1:0] flags, wclr;
    logic             rclr;
    logic [DW-1:0]    irq_ctl;

    hbus_handshake #(.WAIT_STATES(WAIT_STATES)) i_hs (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (bus_cs & bus_stb),
        .ack_o (bus_ack),
        .acc_o (acc)
    );

    hbus_regfile #(.NFLAG(NFLAG)) i_rf (
        .clk          (clk),
        .rst_n        (rst_n),
        .acc_i        (acc),
        .we_i         (bus_we),
        .addr_i       (bus_addr),
        .wdata_i      (bus_wdata),
        .rx_data_i    (core_rx_data),
        .gc_data_i    (core_gc_data),
        .status_i     (core_status),
        .sm_status_i  (core_sm_status),
        .tx_count_i   (core_tx_count),
        .rx_count_i   (core_rx_count),
        .flags_i      (flags),
        .rdata_o      (bus_rdata),
        .ctrl_o       (cfg_ctrl),
        .prescale_o   (cfg_prescale),
        .saddr_o      (cfg_saddr),
        .thresh_o     (cfg_thresh),
        .cmd_o        (cfg_cmd),
        .irq_ctl_o    (irq_ctl),
        .tx_data_o    (tx_data),
        .tx_wr_o      (tx_wr),
        .core_rst_o   (core_rst),
        .txfifo_rst_o (txfifo_rst),
        .rxfifo_rst_o (rxfifo_rst),
        .txcnt_clr_o  (txcnt_clr),
        .rxcnt_clr_o  (rxcnt_clr),
        .flag_wclr_o  (wclr),
        .flag_rclr_o  (rclr)
    );

    hbus_irq_flags #(.NFLAG(NFLAG)) i_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (core_flag_set),
        .wclr_i  (wclr),
        .rclr_i  (rclr),
        .en_i    (irq_ctl[NFLAG-1:0]),
        .force_i (irq_ctl[DW-1]),
        .flags_o (flags),
        .irq_o   (irq)
    );

    p_rdata_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack && bus_cs && bus_stb) |=> (!bus_ack || $stable(bus_rdata)));
    p_no_ack_without_cs_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_ack && !bus_cs) |=> !bus_ack);
endmodule

// File: tb/test_hbus_regslave.sv
// Self-checking bench: a vector table of register accesses, then directed
// tests for side effects, interrupt flags and same-cycle collisions.
module test_hbus_regslave;
    localparam int TB_WAIT = 1;
    localparam int NV = 18;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0, stb = 1'b0, we = 1'b0;
    logic [3:0] addr = '0;
    logic [9:0] wdata = '0;
    logic [9:0] rdata;
    logic       ack;
    logic [9:0] c_rx = '0, c_gc = '0, c_st = '0, c_sm = '0, c_tc = '0, c_rc = '0;
    logic [7:0] fset = '0;
    logic [7:0] o_ctrl, o_cmd;
    logic [15:0] o_pre;
    logic [9:0] o_saddr, o_thr, o_txd;
    logic       o_txw, o_rst, o_txp, o_rxp, o_tcc, o_rcc, o_irq;

    int tests = 0;
    int fails = 0;

    logic [9:0] got_rd;
    logic [9:0] got_txd;
    logic [5:0] got_pulse; // {rst, txw, txp, rxp, tcc, rcc}

    always #2 clk = ~clk;

    hbus_regslave #(.WAIT_STATES(TB_WAIT), .NFLAG(8)) i_hbus_regslave (
        .clk(clk), .rst_n(rst_n), .bus_cs(cs), .bus_stb(stb), .bus_we(we),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .bus_ack(ack),
        .core_rx_data(c_rx), .core_gc_data(c_gc), .core_status(c_st),
        .core_sm_status(c_sm), .core_tx_count(c_tc), .core_rx_count(c_rc),
        .core_flag_set(fset), .cfg_ctrl(o_ctrl), .cfg_prescale(o_pre),
        .cfg_saddr(o_saddr), .cfg_thresh(o_thr), .cfg_cmd(o_cmd),
        .tx_data(o_txd), .tx_wr(o_txw), .core_rst(o_rst), .txfifo_rst(o_txp),
        .rxfifo_rst(o_rxp), .txcnt_clr(o_tcc), .rxcnt_clr(o_rcc), .irq(o_irq)
    );

    // {we, addr, wdata, expected read}
    localparam logic [24:0] VEC [NV] = '{
        {1'b1, 4'h1, 10'h2A5, 10'h000}, {1'b0, 4'h1, 10'h000, 10'h0A5},
        {1'b1, 4'h2, 10'h13C, 10'h000}, {1'b1, 4'h3, 10'h0F1, 10'h000},
        {1'b1, 4'h4, 10'h2E7, 10'h000}, {1'b1, 4'h6, 10'h155, 10'h000},
        {1'b1, 4'h7, 10'h3C3, 10'h000}, {1'b1, 4'h5, 10'h0FF, 10'h000},
        {1'b1, 4'h0, 10'h3FF, 10'h000}, {1'b0, 4'h0, 10'h000, 10'h000},
        {1'b0, 4'h8, 10'h000, 10'h000}, {1'b0, 4'h2, 10'h000, 10'h03C},
        {1'b0, 4'h3, 10'h000, 10'h0F1}, {1'b0, 4'h4, 10'h000, 10'h2E7},
        {1'b0, 4'h6, 10'h000, 10'h155}, {1'b0, 4'h7, 10'h000, 10'h0C3},
        {1'b0, 4'h5, 10'h000, 10'h0FF}, {1'b1, 4'h5, 10'h000, 10'h000}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One bus cycle; setv is driven on the core flag input so that it lands
    // on the acknowledge edge; hold keeps the strobe up for extra cycles.
    task automatic xfer(input logic w, input logic [3:0] a, input logic [9:0] d,
                        input logic [7:0] setv, input int hold);
        int edges;
        @(negedge clk);
        cs = 1'b1; stb = 1'b1; we = w; addr = a; wdata = d;
        edges = 0;
        while (edges < 20) begin
            fset = (edges == TB_WAIT) ? setv : 8'h00;
            @(posedge clk);
            edges++;
            @(negedge clk);
            if (ack) break;
        end
        fset = 8'h00;
        check("R1 ack latency", edges, TB_WAIT + 1);
        got_rd    = rdata;
        got_txd   = o_txd;
        got_pulse = {o_rst, o_txw, o_txp, o_rxp, o_tcc, o_rcc};
        for (int i = 0; i < hold; i++) begin
            c_st = c_st ^ 10'h3FF;
            c_rx = c_rx ^ 10'h3FF;
            @(posedge clk); @(negedge clk);
            check("R3 rdata held", {ack, rdata}, {1'b1, got_rd});
        end
        cs = 1'b0; stb = 1'b0; we = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R1 ack drop", ack, 1'b0);
        check("R2 pulses one cycle", {o_rst, o_txw, o_txp, o_rxp, o_tcc, o_rcc}, 6'b0);
    endtask

    task automatic pulse_flags(input logic [7:0] v);
        @(negedge clk); fset = v;
        @(negedge clk); fset = 8'h00;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R14 reset state
        check("R14 reset outputs", {ack, o_irq, o_rst, o_txw, o_txp, o_rxp, o_tcc, o_rcc}, 8'h00);
        xfer(1'b0, 4'h6, 10'h0, 8'h00, 0);
        check("R14 reset register value", got_rd, 10'h000);

        // R4 / R5 vector table
        for (int v = 0; v < NV; v++) begin
            xfer(VEC[v][24], VEC[v][23:20], VEC[v][19:10], 8'h00, 0);
            if (!VEC[v][24]) check("R4 R5 table read", got_rd, VEC[v][9:0]);
        end

        // R6 core reset pulse
        xfer(1'b1, 4'h2, 10'h03C, 8'h00, 0);
        check("R6 write prescale pulses reset", got_pulse, 6'b100000);
        xfer(1'b0, 4'h2, 10'h000, 8'h00, 0);
        check("R6 read gives no reset", got_pulse, 6'b000000);
        xfer(1'b1, 4'h4, 10'h2E7, 8'h00, 0);
        check("R6 other write gives no reset", got_pulse, 6'b000000);

        // R5 transmit data write
        xfer(1'b1, 4'h8, 10'h2D1, 8'h00, 0);
        check("R5 tx write pulse", got_pulse, 6'b010000);
        check("R5 tx data", got_txd, 10'h2D1);

        // R7 FIFO pointer resets, register mode first
        xfer(1'b1, 4'h1, 10'h000, 8'h00, 0);
        xfer(1'b0, 4'h8, 10'h000, 8'h00, 0);
        check("R7 reg mode tx read", got_pulse, 6'b000000);
        xfer(1'b1, 4'h9, 10'h000, 8'h00, 0);
        check("R7 reg mode rx write", got_pulse, 6'b000000);
        xfer(1'b1, 4'h1, 10'h010, 8'h00, 0);
        xfer(1'b0, 4'h8, 10'h000, 8'h00, 0);
        check("R7 fifo tx read", got_pulse, 6'b001000);
        xfer(1'b1, 4'h9, 10'h000, 8'h00, 0);
        check("R7 fifo rx write", got_pulse, 6'b000100);
        xfer(1'b1, 4'h8, 10'h011, 8'h00, 0);
        check("R7 fifo tx write", got_pulse, 6'b010000);

        // R8 counter clears
        xfer(1'b1, 4'hE, 10'h000, 8'h00, 0);
        check("R8 tx count clear", got_pulse, 6'b000010);
        xfer(1'b1, 4'hF, 10'h000, 8'h00, 0);
        check("R8 rx count clear", got_pulse, 6'b000001);

        // R9 status inputs
        c_rx = 10'h301; c_gc = 10'h0A2; c_st = 10'h1B3;
        c_sm = 10'h0C4; c_tc = 10'h2D5; c_rc = 10'h0E6;
        xfer(1'b0, 4'h9, 10'h0, 8'h00, 0); check("R9 rx data", got_rd, 10'h301);
        xfer(1'b0, 4'hA, 10'h0, 8'h00, 0); check("R9 gc data", got_rd, 10'h0A2);
        xfer(1'b0, 4'hB, 10'h0, 8'h00, 0); check("R9 status", got_rd, 10'h1B3);
        xfer(1'b0, 4'hD, 10'h0, 8'h00, 0); check("R9 sm status", got_rd, 10'h0C4);
        xfer(1'b0, 4'hE, 10'h0, 8'h00, 0); check("R9 tx count", got_rd, 10'h2D5);
        xfer(1'b0, 4'hF, 10'h0, 8'h00, 0); check("R9 rx count", got_rd, 10'h0E6);

        // R3 read data held while the strobe stays up
        c_st = 10'h155;
        xfer(1'b0, 4'hB, 10'h0, 8'h00, 3);
        check("R3 captured value", got_rd, 10'h155);

        // R1 no chip select: no ack, no write
        @(negedge clk);
        cs = 1'b0; stb = 1'b1; we = 1'b1; addr = 4'h6; wdata = 10'h0AA;
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); @(negedge clk);
            check("R1 no ack without cs", ack, 1'b0);
        end
        stb = 1'b0; we = 1'b0;
        xfer(1'b0, 4'h6, 10'h0, 8'h00, 0);
        check("R1 no write without cs", got_rd, 10'h155);

        // R10 flags and write-one clear
        pulse_flags(8'h0F);
        xfer(1'b0, 4'hC, 10'h0, 8'h00, 0); check("R10 flags set", got_rd, 10'h00F);
        xfer(1'b1, 4'hC, 10'h005, 8'h00, 0);
        xfer(1'b0, 4'hC, 10'h0, 8'h00, 0); check("R10 w1c", got_rd, 10'h00A);

        // R13 interrupt request
        check("R13 irq off with enables zero", o_irq, 1'b0);
        xfer(1'b1, 4'h5, 10'h002, 8'h00, 0); check("R13 enabled flag", o_irq, 1'b1);
        xfer(1'b1, 4'h5, 10'h001, 8'h00, 0); check("R13 cleared flag enabled", o_irq, 1'b0);
        xfer(1'b1, 4'h5, 10'h200, 8'h00, 0); check("R13 force", o_irq, 1'b1);
        xfer(1'b1, 4'h5, 10'h000, 8'h00, 0); check("R13 all off", o_irq, 1'b0);

        // R11 read clear
        xfer(1'b0, 4'hC, 10'h0, 8'h00, 0); check("R11 read keeps flags", got_rd, 10'h00A);
        xfer(1'b0, 4'hC, 10'h0, 8'h00, 0); check("R11 still set", got_rd, 10'h00A);
        xfer(1'b1, 4'h5, 10'h100, 8'h00, 0);
        xfer(1'b0, 4'hC, 10'h0, 8'h00, 0); check("R11 auto read value", got_rd, 10'h00A);
        xfer(1'b0, 4'hC, 10'h0, 8'h00, 0); check("R11 auto cleared", got_rd, 10'h000);

        // R12 set and clear on the same edge
        xfer(1'b1, 4'h5, 10'h000, 8'h00, 0);
        pulse_flags(8'h81);
        xfer(1'b1, 4'hC, 10'h081, 8'h01, 0);
        xfer(1'b0, 4'hC, 10'h0, 8'h00, 0); check("R12 set beats w1c", got_rd, 10'h001);
        xfer(1'b1, 4'h5, 10'h100, 8'h00, 0);
        xfer(1'b0, 4'hC, 10'h0, 8'h40, 0); check("R12 read returns old", got_rd, 10'h001);
        xfer(1'b0, 4'hC, 10'h0, 8'h00, 0); check("R12 set beats read clear", got_rd, 10'h040);
        xfer(1'b0, 4'hC, 10'h0, 8'h00, 0); check("R12 cleared after", got_rd, 10'h000);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL R1 watchdog actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule